// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns one high-level flash request into the exact series of command write cycles and status reads that a 16-bit parallel NOR flash expects. A requester presents an operation code, a bank select, a sector index or word address, and a data word. The block then runs the matching unlock and command writes on an abstract single-cycle flash bus and polls the status bit where the operation needs it. It finishes with a one-cycle done pulse, together with an error flag and the collected read data.

Two banks can be reached. The bank with select value 2 sits above the other one on the bus, in the upper half selected by the top address bit. The bus is byte addressed while the flash decodes word addresses, so every flash word offset appears on the bus shifted left by one bit. The block handles one request at a time. It also carries the fast programming mode, in which each word takes only two writes once the unlock-bypass mode has been entered.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, bus_we and bus_re are all 0.
- R2: A request is taken only when busy is 0. It is taken on the clock edge where req_valid is 1. From the next cycle busy stays 1 up to and including the single cycle in which done is 1. Any req_valid raised while busy is 1 has no effect on the bus or on the result.
- R3: Operation codes are: 0 reset, 1 chip erase, 2 sector erase, 3 bypass enter, 4 bypass exit, 5 bypass word program, 6 ID read, 7 invalid. bus_addr is {req_bank[1], byte offset}. Only bank selects 0 and 2 are valid. A request with bank select 1 or 3, or with code 7, gives done with error=1 in the cycle after acceptance, with no bus cycle at all.
- R4: Chip erase issues these writes (data@offset): AA@AAA, 55@554, 80@AAA, AA@AAA, 55@554, 10@AAA. It then reads the bank base until bit 7 of the read word is 1. That final word is returned in rd_data[15:0] with rd_data[31:16]=0 and error=0.
- R5: Sector erase issues the first five chip-erase writes and then writes 30 at twice the sector base. The sector word bases for indices 0 to 18 are 0x00000, 0x02000, 0x03000, 0x04000, 0x08000, then 0x10000 rising in steps of 0x8000 to 0x78000. No polling follows, and error=0.
- R6: A sector erase with an index above 18 gives done with error=1 and no bus cycle.
- R7: Bypass enter writes AA@AAA, 55@554, 20@AAA. Bypass exit writes 90 and then 00, both at the bank base (offset 0). Both end with error=0.
- R8: A word program to word address W writes A0 and then the data word, both at byte offset 2*W. It then reads that offset until bit 7 of the read word equals bit 7 of the data. error is 1 exactly when that final word differs from the data, and the final word is returned in rd_data[15:0].
- R9: A word program with data 0xFFFF produces no bus cycle and gives done with error=0 and rd_data=0 in the cycle after acceptance.
- R10: Reset writes F0 at the bank base and ends with error=0.
- R11: ID read writes AA@AAA, 55@554, 90@AAA. It then reads the bank base and offset 0x200, in that order. rd_data is {second word, first word} and error=0.
- R12: Each cycle carries at most one access, so bus_we and bus_re are never 1 together. Accesses run back to back from the cycle after acceptance, and every accessed bus address has bit 0 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 3 | Operation code |
| req_bank | input | 2 | Bank select (0 or 2 valid) |
| req_sector | input | SECT_W | Sector index for sector erase |
| req_waddr | input | OFS_W-1 | Word address within bank for program |
| req_data | input | DW | Data word for program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Result flag, valid with done |
| rd_data | output | 2*DW | Read result, valid with done |
| bus_addr | output | OFS_W+1 | Byte address on the flash bus |
| bus_wdata | output | DW | Write data on the flash bus |
| bus_rdata | input | DW | Read data, sampled at the end of a read cycle |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |

## Verification
The assertions watch, on every cycle, the properties that hold regardless of the operation. These are: a write and a read never share a cycle, bus addresses stay word aligned, done lasts a single cycle, a request taken while idle raises busy, and invalid bank selects and all-ones program data finish at once without error confusion. Some behaviour only the bench scenarios can show. This covers the exact order of each unlock and command sequence, the sector base lookup, and the length of each poll loop as the flash model keeps status low. It also covers the full-word verify after a program, the ordering of the two ID reads, and the fact that a request raised mid-operation leaves the bus traffic untouched.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_RESET      = 3'd0,
        OP_CHIP_ERASE = 3'd1,
        OP_SECT_ERASE = 3'd2,
        OP_BYP_ENTER  = 3'd3,
        OP_BYP_EXIT   = 3'd4,
        OP_PROGRAM    = 3'd5,
        OP_READ_ID    = 3'd6,
        OP_NONE       = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL,
        ST_RD0,
        ST_RD1,
        ST_FIN
    } state_e;

    // Byte offsets of the two unlock locations (word offsets 555 and 2AA shifted by one)
    localparam logic [11:0] UNLOCK_A   = 12'hAAA;
    localparam logic [11:0] UNLOCK_B   = 12'h554;
    localparam logic [11:0] ID_DEV_OFS = 12'h200;
    localparam int          STAT_BIT   = 7;

    // Word base of a sector: a small boot region followed by uniform 0x8000 sectors
    function automatic logic [31:0] sect_word_base(input logic [7:0] idx);
        case (idx)
            8'd0:    return 32'h0_0000;
            8'd1:    return 32'h0_2000;
            8'd2:    return 32'h0_3000;
            8'd3:    return 32'h0_4000;
            8'd4:    return 32'h0_8000;
            default: return (32'(idx) - 32'd3) << 15;
        endcase
    endfunction

endpackage

// File: rtl/nor_sector_map.sv
module nor_sector_map
    import nor_seq_pkg::*;
#(
    parameter int OFS_W    = 20,
    parameter int SECT_W   = 5,
    parameter int NUM_SECT = 19
) (
    input  logic [SECT_W-1:0] idx,
    output logic [OFS_W-1:0]  base_ofs,
    output logic              valid
);

    logic [OFS_W-1:0] tbl [NUM_SECT];

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_tbl
        assign tbl[g] = OFS_W'(sect_word_base(8'(g)) << 1);
    end

    assign valid = 32'(idx) < NUM_SECT;

    always_comb begin
        base_ofs = '0;
        for (int i = 0; i < NUM_SECT; i++) begin
            if (32'(idx) == i) base_ofs = tbl[i];
        end
    end

endmodule

// File: rtl/nor_step_gen.sv
module nor_step_gen
    import nor_seq_pkg::*;
#(
    parameter int OFS_W = 20,
    parameter int DW    = 16
) (
    input  op_e              op,
    input  logic [2:0]       step,
    input  logic [OFS_W-1:0] tgt,
    input  logic [DW-1:0]    wdata,
    output logic [OFS_W-1:0] ofs,
    output logic [DW-1:0]    data,
    output logic             last
);

    localparam logic [OFS_W-1:0] UA = OFS_W'(UNLOCK_A);
    localparam logic [OFS_W-1:0] UB = OFS_W'(UNLOCK_B);

    always_comb begin
        ofs  = UA;
        data = '0;
        last = 1'b0;
        case (op)
            OP_CHIP_ERASE, OP_SECT_ERASE: begin
                case (step)
                    3'd0: data = DW'(8'hAA);
                    3'd1: begin ofs = UB; data = DW'(8'h55); end
                    3'd2: data = DW'(8'h80);
                    3'd3: data = DW'(8'hAA);
                    3'd4: begin ofs = UB; data = DW'(8'h55); end
                    default: begin
                        last = 1'b1;
                        if (op == OP_SECT_ERASE) begin
                            ofs  = tgt;
                            data = DW'(8'h30);
                        end else begin
                            data = DW'(8'h10);
                        end
                    end
                endcase
            end
            OP_BYP_ENTER, OP_READ_ID: begin
                case (step)
                    3'd0: data = DW'(8'hAA);
                    3'd1: begin ofs = UB; data = DW'(8'h55); end
                    default: begin
                        last = 1'b1;
                        data = (op == OP_READ_ID) ? DW'(8'h90) : DW'(8'h20);
                    end
                endcase
            end
            OP_BYP_EXIT: begin
                ofs  = '0;
                last = (step != 3'd0);
                data = (step == 3'd0) ? DW'(8'h90) : '0;
            end
            OP_PROGRAM: begin
                ofs  = tgt;
                last = (step != 3'd0);
                data = (step == 3'd0) ? DW'(8'hA0) : wdata;
            end
            OP_RESET: begin
                ofs  = '0;
                data = DW'(8'hF0);
                last = 1'b1;
            end
            default: begin
                ofs  = '0;
                last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/nor_poll_eval.sv
module nor_poll_eval
    import nor_seq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          is_prog,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] expect_w,
    output logic          complete,
    output logic          mismatch
);

    always_comb begin
        if (is_prog) begin
            complete = (rdata[STAT_BIT] == expect_w[STAT_BIT]);
            mismatch = (rdata != expect_w);
        end else begin
            complete = rdata[STAT_BIT];
            mismatch = 1'b0;
        end
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int OFS_W    = 20,
    parameter int DW       = 16,
    parameter int SECT_W   = 5,
    parameter int NUM_SECT = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [1:0]        req_bank,
    input  logic [SECT_W-1:0] req_sector,
    input  logic [OFS_W-2:0]  req_waddr,
    input  logic [DW-1:0]     req_data,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [2*DW-1:0]   rd_data,
    output logic [OFS_W:0]    bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    output logic              bus_we,
    output logic              bus_re
);

    state_e           state_q;
    op_e              op_q;
    logic             bank_hi_q;
    logic [OFS_W-1:0] tgt_q;
    logic [DW-1:0]    data_q;
    logic [2:0]       step_q;
    logic             err_q;
    logic [2*DW-1:0]  rd_q;

    op_e              req_op_e;
    logic [OFS_W-1:0] sect_base;
    logic             sect_ok;
    logic             bank_ok;
    logic             reject;
    logic             skip;
    logic [OFS_W-1:0] step_ofs;
    logic [DW-1:0]    step_data;
    logic             step_last;
    logic             poll_done;
    logic             poll_bad;

    assign req_op_e = op_e'(req_op);
    assign bank_ok  = (req_bank == 2'd0) || (req_bank == 2'd2);
    assign reject   = !bank_ok || (req_op_e == OP_NONE) ||
                      ((req_op_e == OP_SECT_ERASE) && !sect_ok);
    assign skip     = (req_op_e == OP_PROGRAM) && (req_data == {DW{1'b1}});

    nor_sector_map #(.OFS_W(OFS_W), .SECT_W(SECT_W), .NUM_SECT(NUM_SECT)) u_map (
        .idx      (req_sector),
        .base_ofs (sect_base),
        .valid    (sect_ok)
    );

    nor_step_gen #(.OFS_W(OFS_W), .DW(DW)) u_steps (
        .op    (op_q),
        .step  (step_q),
        .tgt   (tgt_q),
        .wdata (data_q),
        .ofs   (step_ofs),
        .data  (step_data),
        .last  (step_last)
    );

    nor_poll_eval #(.DW(DW)) u_poll (
        .is_prog  (op_q == OP_PROGRAM),
        .rdata    (bus_rdata),
        .expect_w (data_q),
        .complete (poll_done),
        .mismatch (poll_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_NONE;
            bank_hi_q <= 1'b0;
            tgt_q     <= '0;
            data_q    <= '0;
            step_q    <= '0;
            err_q     <= 1'b0;
            rd_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q      <= req_op_e;
                    bank_hi_q <= req_bank[1];
                    data_q    <= req_data;
                    step_q    <= '0;
                    rd_q      <= '0;
                    err_q     <= reject;
                    if (req_op_e == OP_SECT_ERASE)   tgt_q <= sect_base;
                    else if (req_op_e == OP_PROGRAM) tgt_q <= {req_waddr, 1'b0};
                    else                             tgt_q <= '0;
                    state_q   <= (reject || skip) ? ST_FIN : ST_CMD;
                end
                ST_CMD: begin
                    step_q <= step_q + 3'd1;
                    if (step_last) begin
                        if (op_q == OP_CHIP_ERASE || op_q == OP_PROGRAM) state_q <= ST_POLL;
                        else if (op_q == OP_READ_ID)                     state_q <= ST_RD0;
                        else                                             state_q <= ST_FIN;
                    end
                end
                ST_POLL: if (poll_done) begin
                    rd_q    <= {{DW{1'b0}}, bus_rdata};
                    err_q   <= poll_bad;
                    state_q <= ST_FIN;
                end
                ST_RD0: begin
                    rd_q[DW-1:0] <= bus_rdata;
                    state_q      <= ST_RD1;
                end
                ST_RD1: begin
                    rd_q[2*DW-1:DW] <= bus_rdata;
                    state_q         <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_wdata = '0;
        bus_addr  = {bank_hi_q, {OFS_W{1'b0}}};
        case (state_q)
            ST_CMD: begin
                bus_we    = 1'b1;
                bus_wdata = step_data;
                bus_addr  = {bank_hi_q, step_ofs};
            end
            ST_POLL: begin
                bus_re   = 1'b1;
                bus_addr = {bank_hi_q, tgt_q};
            end
            ST_RD0: bus_re = 1'b1;
            ST_RD1: begin
                bus_re   = 1'b1;
                bus_addr = {bank_hi_q, OFS_W'(ID_DEV_OFS)};
            end
            default: ;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_FIN);
    assign error   = err_q;
    assign rd_data = rd_q;

    // R12
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst) !(bus_we && bus_re));

    // R12
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we || bus_re) |-> !bus_addr[0]);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R3
    bad_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_bank[0]) |=> (done && error && !bus_we && !bus_re));

    // R9
    skip_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !req_bank[0] && req_op == 3'd5 && req_data == {DW{1'b1}})
        |=> (done && !error));

endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [4:0]  req_sector = 5'd0;
    logic [18:0] req_waddr = '0;
    logic [15:0] req_data = '0;
    logic        busy, done, error;
    logic [31:0] rd_data;
    logic [20:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_we, bus_re;

    always #10 clk = ~clk;

    nor_cmd_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_sector(req_sector), .req_waddr(req_waddr),
        .req_data(req_data), .busy(busy), .done(done), .error(error),
        .rd_data(rd_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_we(bus_we), .bus_re(bus_re)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // flash read responses, consumed in order by each read cycle
    logic [15:0] rd_arr [0:1023];
    int rd_idx = 0;
    int rd_fill = 0;
    assign bus_rdata = rd_arr[rd_idx[9:0]];
    always @(posedge clk) if (bus_re) rd_idx <= rd_idx + 1;

    // expected access list: kind 1 = write, 2 = read
    int          exp_kind [0:63];
    logic [20:0] exp_addr [0:63];
    logic [15:0] exp_data [0:63];
    int exp_n = 0, exp_pos = 0, done_seen = 0;
    string cur_tag = "R1";
    bit          exp_err;
    logic [31:0] exp_rd;

    logic [19:0] sect_tbl [0:18] = '{20'h00000, 20'h02000, 20'h03000, 20'h04000,
        20'h08000, 20'h10000, 20'h18000, 20'h20000, 20'h28000, 20'h30000, 20'h38000,
        20'h40000, 20'h48000, 20'h50000, 20'h58000, 20'h60000, 20'h68000, 20'h70000,
        20'h78000};

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic logic [20:0] ba(input bit hi, input logic [19:0] o);
        return {hi, o};
    endfunction

    task automatic ew(input logic [20:0] a, input logic [15:0] d);
        exp_kind[exp_n] = 1; exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
    endtask

    task automatic er(input logic [20:0] a, input logic [15:0] v);
        exp_kind[exp_n] = 2; exp_addr[exp_n] = a; exp_data[exp_n] = '0; exp_n++;
        rd_arr[rd_fill] = v; rd_fill++;
    endtask

    task automatic begin_op();
        @(posedge clk); #1;
        exp_n = 0; exp_pos = 0; done_seen = 0;
    endtask

    task automatic erase_prefix(input bit hi);
        ew(ba(hi, 20'hAAA), 16'h00AA); ew(ba(hi, 20'h554), 16'h0055);
        ew(ba(hi, 20'hAAA), 16'h0080); ew(ba(hi, 20'hAAA), 16'h00AA);
        ew(ba(hi, 20'h554), 16'h0055);
    endtask

    // cycle-by-cycle comparison against the expected access list
    always @(negedge clk) begin
        if (!rst) begin
            if (!busy) begin
                chk(!bus_we && !bus_re && !done, cur_tag, "idle quiet {we,re,done}",
                    {29'd0, bus_we, bus_re, done}, 32'd0);
            end else if (exp_pos < exp_n) begin
                chk(bus_we == (exp_kind[exp_pos] == 1) && bus_re == (exp_kind[exp_pos] == 2) && !done,
                    cur_tag, "access kind {we,re,done}", {29'd0, bus_we, bus_re, done},
                    {29'd0, exp_kind[exp_pos] == 1, exp_kind[exp_pos] == 2, 1'b0});
                chk(bus_addr == exp_addr[exp_pos], cur_tag, "bus address",
                    {11'd0, bus_addr}, {11'd0, exp_addr[exp_pos]});
                if (exp_kind[exp_pos] == 1)
                    chk(bus_wdata == exp_data[exp_pos], cur_tag, "write data",
                        {16'd0, bus_wdata}, {16'd0, exp_data[exp_pos]});
                exp_pos++;
            end else begin
                chk(done && !bus_we && !bus_re, cur_tag, "completion {we,re,done}",
                    {29'd0, bus_we, bus_re, done}, 32'd1);
                chk(error == exp_err, cur_tag, "error flag", {31'd0, error}, {31'd0, exp_err});
                chk(rd_data == exp_rd, cur_tag, "read data", rd_data, exp_rd);
                done_seen++;
            end
        end
    end

    task automatic run_op(input string tag, input logic [2:0] op, input logic [1:0] bank,
                          input logic [4:0] sect, input logic [18:0] wa, input logic [15:0] d,
                          input bit nudge, input bit e_err, input logic [31:0] e_rd);
        cur_tag = tag; exp_err = e_err; exp_rd = e_rd;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_bank = bank;
        req_sector = sect; req_waddr = wa; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (nudge) begin
            repeat (2) @(negedge clk);
            req_valid = 1'b1; req_op = 3'd0; req_bank = 2'd0;
            repeat (2) @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(done_seen == 1 && exp_pos == exp_n, tag, "one completion after all accesses",
            32'(done_seen), 32'd1);
    endtask

    initial begin
        #3000000;
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) rd_arr[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !bus_we && !bus_re, "R1", "outputs in reset",
            {28'd0, busy, done, bus_we, bus_re}, 32'd0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !bus_we && !bus_re, "R1", "outputs after reset",
            {28'd0, busy, done, bus_we, bus_re}, 32'd0);

        // R10: reset command, bank 0
        begin_op(); ew(ba(0, 20'h0), 16'h00F0);
        run_op("R10", 3'd0, 2'd0, 5'd0, '0, '0, 0, 0, 32'd0);

        // R4: chip erase, bank 2, status low twice then high
        begin_op(); erase_prefix(1); ew(ba(1, 20'hAAA), 16'h0010);
        er(ba(1, 20'h0), 16'h0000); er(ba(1, 20'h0), 16'h0040); er(ba(1, 20'h0), 16'h00A4);
        run_op("R4", 3'd1, 2'd2, 5'd0, '0, '0, 0, 0, 32'h0000_00A4);

        // R5: sector erase at indices 0, 4, 18
        foreach (sect_tbl[k]) begin
            if (k == 0 || k == 4 || k == 18) begin
                begin_op(); erase_prefix(0);
                ew(ba(0, sect_tbl[k] << 1), 16'h0030);
                run_op("R5", 3'd2, 2'd0, 5'(k), '0, '0, 0, 0, 32'd0);
            end
        end
        begin_op(); erase_prefix(1); ew(ba(1, sect_tbl[7] << 1), 16'h0030);
        run_op("R5", 3'd2, 2'd2, 5'd7, '0, '0, 0, 0, 32'd0);

        // R6: sector index out of range
        begin_op(); run_op("R6", 3'd2, 2'd0, 5'd19, '0, '0, 0, 1, 32'd0);
        begin_op(); run_op("R6", 3'd2, 2'd2, 5'd31, '0, '0, 0, 1, 32'd0);

        // R3: invalid bank selects and invalid op code
        begin_op(); run_op("R3", 3'd0, 2'd1, 5'd0, '0, '0, 0, 1, 32'd0);
        begin_op(); run_op("R3", 3'd1, 2'd3, 5'd0, '0, '0, 0, 1, 32'd0);
        begin_op(); run_op("R3", 3'd7, 2'd0, 5'd0, '0, '0, 0, 1, 32'd0);

        // R7: bypass enter on bank 0, exit on bank 2
        begin_op(); ew(ba(0, 20'hAAA), 16'h00AA); ew(ba(0, 20'h554), 16'h0055);
        ew(ba(0, 20'hAAA), 16'h0020);
        run_op("R7", 3'd3, 2'd0, 5'd0, '0, '0, 0, 0, 32'd0);
        begin_op(); ew(ba(1, 20'h0), 16'h0090); ew(ba(1, 20'h0), 16'h0000);
        run_op("R7", 3'd4, 2'd2, 5'd0, '0, '0, 0, 0, 32'd0);

        // R8: program success after one busy poll
        begin_op(); ew(ba(0, 20'h02468), 16'h00A0); ew(ba(0, 20'h02468), 16'h5A5A);
        er(ba(0, 20'h02468), 16'hFF80); er(ba(0, 20'h02468), 16'h5A5A);
        run_op("R8", 3'd5, 2'd0, 5'd0, 19'h01234, 16'h5A5A, 0, 0, 32'h0000_5A5A);
        // R8: program with bit 7 matching but word differing
        begin_op(); ew(ba(1, 20'h00020), 16'h00A0); ew(ba(1, 20'h00020), 16'h1280);
        er(ba(1, 20'h00020), 16'h0000); er(ba(1, 20'h00020), 16'h1380);
        run_op("R8", 3'd5, 2'd2, 5'd0, 19'h00010, 16'h1280, 0, 1, 32'h0000_1380);

        // R9: all-ones data is skipped
        begin_op(); run_op("R9", 3'd5, 2'd0, 5'd0, 19'h00055, 16'hFFFF, 0, 0, 32'd0);

        // R11: ID read on bank 2
        begin_op(); ew(ba(1, 20'hAAA), 16'h00AA); ew(ba(1, 20'h554), 16'h0055);
        ew(ba(1, 20'hAAA), 16'h0090);
        er(ba(1, 20'h0), 16'h0001); er(ba(1, 20'h200), 16'h22DA);
        run_op("R11", 3'd6, 2'd2, 5'd0, '0, '0, 0, 0, 32'h22DA_0001);

        // R2: request raised mid-operation is ignored
        begin_op(); erase_prefix(0); ew(ba(0, 20'hAAA), 16'h0010);
        for (int p = 0; p < 5; p++) er(ba(0, 20'h0), 16'h007F);
        er(ba(0, 20'h0), 16'h0080);
        run_op("R2", 3'd1, 2'd0, 5'd0, '0, '0, 1, 0, 32'h0000_0080);

        // R12: idle bus after the last operation
        repeat (3) @(negedge clk);
        chk(!bus_we && !bus_re && !busy, "R12", "bus idle at end",
            {29'd0, bus_we, bus_re, busy}, 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule